// File: doc/BRIEF.md
# Framed serial DAC command receiver

This block sits in front of a digital-to-analog converter and turns a three-wire serial command stream into parallel settings. The three wires are an active-low frame line, a serial bit clock and a serial data line. A fast system clock oversamples all three. Each command frame carries 16 bits, most significant bit first. The two leading bits choose a power state. The converter code follows them, left-justified, with a width of 8, 10 or 12 bits chosen by a parameter. Any bits below the code are discarded.

A frame opens only on a falling edge of the frame line. Each falling edge of the bit clock shifts in one data bit. On the sixteenth falling edge the frame executes: the held power-state and code registers take the new values, and a load strobe pulses for one system clock. After that the receiver ignores the bit clock until the frame line has gone high and then low again. If the frame line rises before sixteen bits have arrived, the partial frame is dropped. When the frame line was high for fewer system clocks than a set minimum before it falls again, a one-cycle warning pulse is raised.

Top module: `sdac_cmd_rx`

## Requirements
- R1: After reset, `pwr_mode` is 2'b01 (a power-down state), `dac_code` is zero, and `load_stb` and `rearm_short` are low.
- R2: A frame's first received bit is word bit 15. `pwr_mode` takes word bits [15:14], where 2'b00 means normal operation and 2'b01, 2'b10 and 2'b11 are three power-down states.
- R3: `dac_code` takes the CODE_W bits directly below the mode bits, word bits [13 -: CODE_W]. The lower 14-CODE_W bits have no effect on any output.
- R4: Each frame that completes with sixteen bit-clock falling edges gives exactly one `load_stb` pulse, one system clock wide. `pwr_mode` and `dac_code` change only in the cycle that pulse is high.
- R5: Bit-clock edges while the frame line is high never execute a frame.
- R6: Once sixteen bits have been taken, further bit-clock edges while the frame line stays low are ignored, and no new frame begins until the frame line has risen and fallen again.
- R7: If the frame line rises after fewer than sixteen bits, the partial frame is dropped: no load pulse, and the outputs keep their earlier values. The next frame is decoded from its own first bit.
- R8: `rearm_short` pulses for one cycle when the frame line falls after being high for fewer than MIN_HIGH_CLKS system clocks. A high time of exactly MIN_HIGH_CLKS gives no pulse.
- R9: A frame opened by a short re-arm is still received and executed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| frm_n | input | 1 | Active-low frame line; its falling edge opens a frame |
| bclk | input | 1 | Serial bit clock; data is taken on its falling edges |
| bdat | input | 1 | Serial data, most significant bit first |
| pwr_mode | output | 2 | Held power-state field (00 normal, others power-down) |
| dac_code | output | CODE_W | Held converter code |
| load_stb | output | 1 | One-cycle pulse when a frame executes |
| rearm_short | output | 1 | One-cycle pulse on a frame-line fall after too short a high time |

## Verification
Two situations are the hardest to reach from the ports. The first is the exact boundary of the re-arm timer. The stimulus raises the frame line for exactly MIN_HIGH_CLKS-1 system clocks and then for exactly MIN_HIGH_CLKS, and it drives every change on the falling system-clock edge so the synchronized high time matches the driven one to the cycle. The second is the state after a completed frame while the frame line stays low. The bench keeps the line low and sends a short burst and then a full sixteen further bit-clock edges with different data, and it checks that the load strobe count and the held registers do not move.

// File: rtl/sdac_rx_pkg.sv
package sdac_rx_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'b00,
    FR_SHIFT = 2'b01,
    FR_DONE  = 2'b10
  } fr_state_e;

  localparam logic [1:0] PM_NORMAL   = 2'b00;
  localparam logic [1:0] PM_RST_MODE = 2'b01;

  localparam int LN_FRM  = 0;
  localparam int LN_BCLK = 1;
  localparam int LN_BDAT = 2;
  localparam int N_LINES = 3;
endpackage

// File: rtl/sdac_line_sync.sv
module sdac_line_sync #(
  parameter int               N       = 3,
  parameter int               STAGES  = 2,
  parameter logic [N-1:0]     RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= {STAGES{RST_VAL[g]}};
        prev  <= RST_VAL[g];
      end else begin
        chain <= {chain[STAGES-2:0], raw[g]};
        prev  <= chain[STAGES-1];
      end
    end

    assign lvl[g]  = chain[STAGES-1];
    assign fall[g] = prev & ~chain[STAGES-1];
  end
endmodule

// File: rtl/sdac_frame_shift.sv
module sdac_frame_shift
  import sdac_rx_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frm_lvl,
  input  logic                  frm_fall,
  input  logic                  bclk_fall,
  input  logic                  bdat_s,
  output logic [FRAME_BITS-1:0] word,
  output logic                  done
);
  localparam int                CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(FRAME_BITS - 1);

  fr_state_e        state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FR_IDLE;
      cnt   <= '0;
      word  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        FR_IDLE: begin
          if (frm_fall) begin
            state <= FR_SHIFT;
            cnt   <= '0;
          end
        end
        FR_SHIFT: begin
          if (frm_lvl) begin
            state <= FR_IDLE;      // partial frame dropped
            cnt   <= '0;
          end else if (bclk_fall) begin
            word <= {word[FRAME_BITS-2:0], bdat_s};
            if (cnt == LAST) begin
              done  <= 1'b1;
              state <= FR_DONE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        FR_DONE: begin
          if (frm_lvl) state <= FR_IDLE;
        end
        default: state <= FR_IDLE;
      endcase
    end
  end

  // R4: the execute flag is only raised as the frame enters its done state
  p_done_state_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == FR_DONE));

  // R5 R6: nothing executes unless the receiver was shifting
  p_no_exec_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (state != FR_SHIFT) |=> !done);
endmodule

// File: rtl/sdac_rearm_guard.sv
module sdac_rearm_guard #(
  parameter int MIN_HIGH_CLKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic frm_lvl,
  input  logic frm_fall,
  output logic short_pulse
);
  localparam int             HW   = $clog2(MIN_HIGH_CLKS + 1);
  localparam logic [HW-1:0]  HMAX = HW'(MIN_HIGH_CLKS);

  logic [HW-1:0] high_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      high_cnt    <= HMAX;
      short_pulse <= 1'b0;
    end else begin
      if (frm_lvl) begin
        if (high_cnt != HMAX) high_cnt <= high_cnt + 1'b1;
      end else begin
        high_cnt <= '0;
      end
      short_pulse <= frm_fall && (high_cnt < HMAX);
    end
  end

  // R8: a warning only follows a cycle in which the line was already low
  p_warn_after_low_r8: assert property (@(posedge clk) disable iff (rst)
    frm_lvl |=> !short_pulse);

  // R8: the warning lasts one cycle
  p_warn_single_r8: assert property (@(posedge clk) disable iff (rst)
    short_pulse |=> !short_pulse);
endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx
  import sdac_rx_pkg::*;
#(
  parameter int CODE_W        = 12,
  parameter int FRAME_BITS    = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_HIGH_CLKS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_n,
  input  logic              bclk,
  input  logic              bdat,
  output logic [1:0]        pwr_mode,
  output logic [CODE_W-1:0] dac_code,
  output logic              load_stb,
  output logic              rearm_short
);
  localparam int CODE_LSB = FRAME_BITS - 2 - CODE_W;
  localparam int MODE_MSB = FRAME_BITS - 1;

  logic [N_LINES-1:0]    raw_in, lvl, fall;
  logic [FRAME_BITS-1:0] word;
  logic                  frame_done;

  assign raw_in[LN_FRM]  = frm_n;
  assign raw_in[LN_BCLK] = bclk;
  assign raw_in[LN_BDAT] = bdat;

  sdac_line_sync #(
    .N       (N_LINES),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b011)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .raw  (raw_in),
    .lvl  (lvl),
    .fall (fall)
  );

  sdac_frame_shift #(
    .FRAME_BITS (FRAME_BITS)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .frm_lvl   (lvl[LN_FRM]),
    .frm_fall  (fall[LN_FRM]),
    .bclk_fall (fall[LN_BCLK]),
    .bdat_s    (lvl[LN_BDAT]),
    .word      (word),
    .done      (frame_done)
  );

  sdac_rearm_guard #(
    .MIN_HIGH_CLKS (MIN_HIGH_CLKS)
  ) u_rearm (
    .clk         (clk),
    .rst         (rst),
    .frm_lvl     (lvl[LN_FRM]),
    .frm_fall    (fall[LN_FRM]),
    .short_pulse (rearm_short)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_mode <= PM_RST_MODE;
      dac_code <= '0;
      load_stb <= 1'b0;
    end else begin
      load_stb <= frame_done;
      if (frame_done) begin
        pwr_mode <= word[MODE_MSB -: 2];
        dac_code <= word[CODE_LSB +: CODE_W];
      end
    end
  end

  // R4: the load strobe is one cycle wide
  p_load_single_r4: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> !load_stb);

  // R6 R7: held settings move only when a frame executes
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> ($stable(pwr_mode) && $stable(dac_code)));
endmodule

// File: tb/sdac_cmd_rx_bench.sv
module sdac_cmd_rx_bench;
  localparam int CW   = 12;
  localparam int MINH = 5;
  localparam logic [15:0] DC_MASK = 16'((32'd1 << (14 - CW)) - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_n = 1'b1, bclk = 1'b1, bdat = 1'b0;
  logic [1:0]    pwr_mode;
  logic [CW-1:0] dac_code;
  logic          load_stb, rearm_short;

  int n_vec = 0, n_bad = 0, loads = 0, warns = 0;
  logic [1:0]    exp_mode;
  logic [CW-1:0] exp_code;

  always #2 clk = ~clk;

  sdac_cmd_rx #(.CODE_W(CW), .MIN_HIGH_CLKS(MINH)) u_sdac_cmd_rx (
    .clk(clk), .rst(rst), .frm_n(frm_n), .bclk(bclk), .bdat(bdat),
    .pwr_mode(pwr_mode), .dac_code(dac_code),
    .load_stb(load_stb), .rearm_short(rearm_short)
  );

  always @(posedge clk) if (!rst) begin
    if (load_stb) loads++;
    if (rearm_short) warns++;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic shift_bits(logic [15:0] w, int n);
    for (int i = 0; i < n; i++) begin
      bdat = w[15 - i];
      tick(2); bclk = 1'b0;
      tick(3); bclk = 1'b1;
      tick(2);
    end
  endtask

  task automatic open_frame();
    frm_n = 1'b0; tick(3);
  endtask

  task automatic close_frame(int h);
    frm_n = 1'b1; tick(h);
  endtask

  task automatic check_held(string tag);
    chk({tag, " mode"}, 32'(pwr_mode), 32'(exp_mode));
    chk({tag, " code"}, 32'(dac_code), 32'(exp_code));
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(pwr_mode), 32'h1);
    chk("R1 code", 32'(dac_code), 32'h0);
    chk("R1 load", 32'(load_stb), 32'h0);
    chk("R1 warn", 32'(rearm_short), 32'h0);
    exp_mode = 2'b01; exp_code = '0;
  endtask

  task automatic t_frame(logic [15:0] w);
    int l0 = loads;
    open_frame();
    shift_bits(w, 16);
    tick(8);
    exp_mode = w[15:14];
    exp_code = w[13 -: CW];
    chk("R4 one load", 32'(loads), 32'(l0 + 1));
    chk("R2 mode", 32'(pwr_mode), 32'(exp_mode));
    chk("R3 code", 32'(dac_code), 32'(exp_code));
    close_frame(10);
  endtask

  task automatic t_dont_care(logic [15:0] w);
    logic [CW-1:0] first;
    t_frame(w & ~DC_MASK);
    first = dac_code;
    t_frame(w | DC_MASK);
    chk("R3 low bits ignored", 32'(dac_code), 32'(first));
  endtask

  task automatic t_clocks_while_high();
    int l0 = loads;
    shift_bits(16'h5A5A, 16);
    tick(8);
    chk("R5 no load with frame high", 32'(loads), 32'(l0));
    check_held("R5");
  endtask

  task automatic t_extra_clocks(logic [15:0] w);
    int l0 = loads;
    open_frame();
    shift_bits(w, 16);
    tick(8);
    exp_mode = w[15:14];
    exp_code = w[13 -: CW];
    shift_bits(~w, 5);
    tick(8);
    chk("R6 extra edges no load", 32'(loads), 32'(l0 + 1));
    check_held("R6 after burst");
    shift_bits(~w, 16);
    tick(8);
    chk("R6 no second frame while low", 32'(loads), 32'(l0 + 1));
    check_held("R6 after 16 more");
    close_frame(10);
  endtask

  task automatic t_abort();
    int l0 = loads;
    open_frame();
    shift_bits(16'hFFFF, 9);
    tick(4);
    close_frame(10);
    chk("R7 no load on partial", 32'(loads), 32'(l0));
    check_held("R7");
    t_frame(16'h2963);
  endtask

  task automatic t_rearm();
    int w0;
    open_frame();
    shift_bits(16'h1234, 16);
    tick(8);
    w0 = warns;
    close_frame(MINH - 1);
    open_frame();
    tick(3);
    chk("R8 short high warns", 32'(warns), 32'(w0 + 1));
    shift_bits(16'hB00F, 16);
    tick(8);
    exp_mode = 2'b10;
    exp_code = 16'hB00F >> (14 - CW);
    check_held("R9 frame after short re-arm");
    w0 = warns;
    close_frame(MINH);
    open_frame();
    tick(6);
    chk("R8 exact minimum no warn", 32'(warns), 32'(w0));
    close_frame(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(10);
    t_reset();
    t_frame(16'h3ABC);
    t_frame(16'hC001);
    t_frame(16'h7FFD);
    t_frame(16'h8E5B);
    t_dont_care(16'h4C6C);
    t_clocks_while_high();
    t_extra_clocks(16'hD5A6);
    t_abort();
    t_rearm();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule